// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master

This block is the station-management master for an Ethernet PHY. Software talks to it through four word registers on a simple write-strobe bus with a combinational read port. One register holds the target PHY address, the register number inside that PHY and a direction flag. A second holds the 16-bit value for a write. A third returns the 16-bit result of a read. The fourth is a control register with an interface-enable bit and a busy bit.

To run a transaction, software writes the control register with both the enable bit and the busy bit set. The block then sends one complete clause 22 management frame on MDC/MDIO and keeps the busy bit at one until the last bit period has finished. MDIO is driven through a separate output-enable, so it can connect to a tri-state pad with an external pull-up. MDC comes from the system clock through a parameterized divider and stays low whenever no frame is in flight. On a read, the master releases the line from turnaround to the end of the frame and shifts in the PHY's reply on rising MDC edges. If no PHY answers, the pull-up makes the result all ones.

Top module: `mdio_mgmt_master`

## Requirements
- R1: In the address register, bits [4:0] give the PHY register number, bits [9:5] give the PHY address and bit 10 picks the direction (1 = read, 0 = write). These fields appear in the frame as the 5-bit PHY address followed by the 5-bit register number, each MSB first.
- R2: A write frame is 64 MDC periods long. It is 32 ones, start code 01, opcode 01, PHY address, register number, turnaround 10, then write-data bits [15:0] MSB first. MDIO is driven for all 64 bits.
- R3: A read frame uses opcode 10. The master drives bits 0 to 45 and releases MDIO for bits 46 to 63. It samples one bit on each rising MDC edge of bits 48 to 63, MSB first, and places the 16-bit result in bits [15:0] of the read-data register when the frame ends.
- R4: Control bit 0 is busy. A control write with bits 0 and 3 both set starts a frame. Bit 0 then reads 1 for exactly 128*MDC_HALF clock cycles after the write edge and returns to 0 without software action.
- R5: If the enable bit (control bit 3) is 0 in the control write, setting bit 0 has no effect. Busy reads 0 and MDC stays low.
- R6: Control bit 3 reads back the last value written when HAS_MDIO=1. It always reads 0 when HAS_MDIO=0, and such an instance never starts a frame.
- R7: MDC is low while idle. While a frame runs, MDC is high for MDC_HALF cycles per period, giving 64 rising edges and 64*MDC_HALF high cycles in total. The MDIO output changes only while MDC is low.
- R8: A read that gets no reply from any PHY returns 0xFFFF.
- R9: The registers sit at byte offsets 0x7E4 (address), 0x7E8 (write data), 0x7EC (read data) and 0x7F0 (control). The address register reads back bits [10:0] and the write-data register reads back bits [15:0]. Writes to the read-data offset are ignored. After reset every register reads 0, and both MDC and the MDIO output-enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO pad input |

## Verification
A wrong bit counter or a frame register that is misaligned shows up as a wrong bit at a fixed position of the captured frame. A wrong divider state shows up as a wrong high-time total and a wrong busy length, both visible within one frame of a few hundred cycles. A direction flag that is latched wrongly shows up as the line being driven during turnaround, or released too early, within the first 48 MDC periods. A broken start qualifier shows up at once as busy reading 1 with the interface disabled, or as a frame on the instance built without MDIO.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int PHY_AW     = 5;
   localparam int REG_AW     = 5;
   localparam int MDATA_W    = 16;
   localparam int FLD_REG_LO = 0;
   localparam int FLD_PHY_LO = 5;
   localparam int FLD_DIR    = 10;
   localparam int CTL_BUSY   = 0;
   localparam int CTL_EN     = 3;

   localparam logic [1:0] SOF_CODE = 2'b01;
   localparam logic [1:0] OP_RD    = 2'b10;
   localparam logic [1:0] OP_WR    = 2'b01;
   localparam logic [1:0] TA_CODE  = 2'b10;

   typedef struct packed {
      logic               rd;
      logic [PHY_AW-1:0]  phy;
      logic [REG_AW-1:0]  regn;
      logic [MDATA_W-1:0] wdata;
   } mdio_cmd_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int MDC_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic fall
);
   logic tick;
   logic mdc_q;

   generate
      if (MDC_HALF < 1) begin : g_bad
         $error("MDC_HALF must be at least 1");
      end
      if (MDC_HALF == 1) begin : g_fast
         assign tick = run;
      end else begin : g_cnt
         localparam int CW = $clog2(MDC_HALF);
         localparam logic [CW-1:0] RELOAD = CW'(MDC_HALF - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               cnt_q <= RELOAD;
            end else if (cnt_q == '0) begin
               cnt_q <= RELOAD;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign tick = run && (cnt_q == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         mdc_q <= 1'b0;
      end else if (tick) begin
         mdc_q <= ~mdc_q;
      end
   end

   assign mdc  = mdc_q;
   assign rise = tick && !mdc_q;
   assign fall = tick && mdc_q;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_mgmt_pkg::*;
#(
   parameter int PREAMBLE = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  mdio_cmd_t          cmd,
   input  logic               rise,
   input  logic               fall,
   input  logic               mdio_i,
   output logic               busy,
   output logic               op_rd,
   output logic [$clog2(PREAMBLE+32)-1:0] bit_idx,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic [MDATA_W-1:0] rd_word
);
   localparam int LEN      = PREAMBLE + 32;
   localparam int IW       = $clog2(LEN);
   localparam int TA_POS   = PREAMBLE + 14;
   localparam int DATA_POS = PREAMBLE + 16;
   localparam logic [IW-1:0] LAST = IW'(LEN - 1);

   generate
      if (PREAMBLE < 1) begin : g_bad
         $error("PREAMBLE must be at least 1");
      end
   endgenerate

   logic [LEN-1:0]     frame_q;
   logic [MDATA_W-1:0] shift_q;
   logic [IW-1:0]      idx_nxt;

   assign idx_nxt = bit_idx + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         op_rd   <= 1'b0;
         bit_idx <= '0;
         frame_q <= '0;
         mdio_oe <= 1'b0;
         shift_q <= '0;
         rd_word <= '0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         op_rd   <= cmd.rd;
         bit_idx <= '0;
         frame_q <= {{PREAMBLE{1'b1}}, SOF_CODE, (cmd.rd ? OP_RD : OP_WR),
                     cmd.phy, cmd.regn, TA_CODE, cmd.wdata};
         mdio_oe <= 1'b1;
      end else if (busy) begin
         if (rise && op_rd && (bit_idx >= IW'(DATA_POS))) begin
            shift_q <= {shift_q[MDATA_W-2:0], mdio_i};
         end
         if (fall) begin
            if (bit_idx == LAST) begin
               busy    <= 1'b0;
               mdio_oe <= 1'b0;
               if (op_rd) begin
                  rd_word <= shift_q;
               end
            end else begin
               bit_idx <= idx_nxt;
               frame_q <= {frame_q[LEN-2:0], 1'b0};
               mdio_oe <= !op_rd || (idx_nxt < IW'(TA_POS));
            end
         end
      end
   end

   assign mdio_o = busy ? frame_q[LEN-1] : 1'b1;

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int HAS_MDIO  = 1,
   parameter logic [ADDR_W-1:0] OFS_ADDR  = ADDR_W'('h7E4),
   parameter logic [ADDR_W-1:0] OFS_WDATA = ADDR_W'('h7E8),
   parameter logic [ADDR_W-1:0] OFS_RDATA = ADDR_W'('h7EC),
   parameter logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'('h7F0)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               busy,
   input  logic [MDATA_W-1:0] rd_word,
   output mdio_cmd_t          cmd,
   output logic               start,
   output logic               en_q
);
   localparam int AREG_W = FLD_DIR + 1;

   generate
      if (DATA_W < 16) begin : g_bad_w
         $error("DATA_W must hold at least 16 bits");
      end
   endgenerate

   logic [AREG_W-1:0]  areg_q;
   logic [MDATA_W-1:0] wreg_q;
   logic               wr_ctrl;
   logic               en_wr;

   assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);

   generate
      if (HAS_MDIO != 0) begin : g_en
         assign en_wr = bus_wdata[CTL_EN];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q <= 1'b0;
            end else if (wr_ctrl) begin
               en_q <= en_wr;
            end
         end
      end else begin : g_no_en
         assign en_wr = 1'b0;
         assign en_q  = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         areg_q <= '0;
         wreg_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == OFS_ADDR) begin
            areg_q <= bus_wdata[AREG_W-1:0];
         end
         if (bus_addr == OFS_WDATA) begin
            wreg_q <= bus_wdata[MDATA_W-1:0];
         end
      end
   end

   assign start = wr_ctrl && bus_wdata[CTL_BUSY] && en_wr && !busy;

   assign cmd.rd    = areg_q[FLD_DIR];
   assign cmd.phy   = areg_q[FLD_PHY_LO +: PHY_AW];
   assign cmd.regn  = areg_q[FLD_REG_LO +: REG_AW];
   assign cmd.wdata = wreg_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFS_ADDR) begin
         bus_rdata = DATA_W'(areg_q);
      end else if (bus_addr == OFS_WDATA) begin
         bus_rdata = DATA_W'(wreg_q);
      end else if (bus_addr == OFS_RDATA) begin
         bus_rdata = DATA_W'(rd_word);
      end else if (bus_addr == OFS_CTRL) begin
         bus_rdata[CTL_BUSY] = busy;
         bus_rdata[CTL_EN]   = en_q;
      end
   end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int MDC_HALF = 2,
   parameter int PREAMBLE = 32,
   parameter int HAS_MDIO = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   localparam int IW = $clog2(PREAMBLE + 32);

   mdio_cmd_t          reg_cmd;
   logic               reg_start;
   logic               reg_en;
   logic               eng_busy;
   logic               eng_rd;
   logic [IW-1:0]      eng_idx;
   logic [MDATA_W-1:0] eng_word;
   logic               div_rise;
   logic               div_fall;

   mdio_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .HAS_MDIO (HAS_MDIO)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .busy      (eng_busy),
      .rd_word   (eng_word),
      .cmd       (reg_cmd),
      .start     (reg_start),
      .en_q      (reg_en)
   );

   mdio_clk_div #(
      .MDC_HALF (MDC_HALF)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (eng_busy),
      .mdc   (mdc),
      .rise  (div_rise),
      .fall  (div_fall)
   );

   mdio_frame_engine #(
      .PREAMBLE (PREAMBLE)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (reg_start),
      .cmd     (reg_cmd),
      .rise    (div_rise),
      .fall    (div_fall),
      .mdio_i  (mdio_i),
      .busy    (eng_busy),
      .op_rd   (eng_rd),
      .bit_idx (eng_idx),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .rd_word (eng_word)
   );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
   parameter int MDC_HALF = 2,
   parameter int PREAMBLE = 32
) (
   input logic clk,
   input logic rst_n,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe,
   input logic eng_busy,
   input logic eng_rd,
   input logic reg_en,
   input logic [$clog2(PREAMBLE+32)-1:0] eng_idx
);
   localparam int IW      = $clog2(PREAMBLE + 32);
   localparam int MAXC    = (PREAMBLE + 32) * 2 * MDC_HALF;
   localparam int TA_POS  = PREAMBLE + 14;

   int unsigned busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !eng_busy) begin
         busy_cnt <= 0;
      end else begin
         busy_cnt <= busy_cnt + 1;
      end
   end

   // R7: clock parked low outside a frame
   a_r7_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !mdc);

   // R7: data only moves while the clock is low
   a_r7_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> $stable(mdio_o));

   // R3: line released from turnaround onward on reads
   a_r3_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && eng_rd && (eng_idx >= IW'(TA_POS))) |-> !mdio_oe);

   // R2: the pad is driven only inside a frame
   a_r2_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> eng_busy);

   // R5: no frame starts with the interface disabled
   a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_busy) |-> reg_en);

   // R4: busy never outlasts one frame
   a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> (busy_cnt < MAXC));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(
   .MDC_HALF (MDC_HALF),
   .PREAMBLE (PREAMBLE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .eng_busy (eng_busy),
   .eng_rd   (eng_rd),
   .reg_en   (reg_en),
   .eng_idx  (eng_idx)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 3;
   localparam int AW         = 12;
   localparam logic [AW-1:0] A_ADDR  = 12'h7E4;
   localparam logic [AW-1:0] A_WDATA = 12'h7E8;
   localparam logic [AW-1:0] A_RDATA = 12'h7EC;
   localparam logic [AW-1:0] A_CTRL  = 12'h7F0;
   localparam int NVEC = 5;
   // {rd, phy[4:0], reg[4:0], data[15:0], phy_answers}
   localparam logic [27:0] VEC [NVEC] = '{
      {1'b0, 5'h01, 5'h00, 16'hA55A, 1'b0},
      {1'b1, 5'h1F, 5'h01, 16'h7809, 1'b1},
      {1'b0, 5'h10, 5'h1F, 16'h0001, 1'b0},
      {1'b1, 5'h00, 5'h02, 16'h8000, 1'b1},
      {1'b1, 5'h0A, 5'h15, 16'h1234, 1'b0}
   };

   logic        clk = 0;
   logic        rst_n = 0;
   logic [AW-1:0] bus_addr = '0;
   logic        bus_wr = 0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata, rdata2;
   logic        mdc, mdo, moe, mdi;
   logic        mdc2, mdo2, moe2;

   int errors = 0;
   int checks = 0;

   logic        clr_req = 0;
   logic        prev_mdc = 0;
   int          fcount = 0;
   int          hi_cnt = 0;
   logic [63:0] cap_v = '0;
   logic [63:0] capoe_v = '0;
   logic        resp_en = 0;
   logic [15:0] resp_word = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_mgmt_master #(.MDC_HALF(HALF), .HAS_MDIO(1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata), .mdc(mdc), .mdio_o(mdo),
      .mdio_oe(moe), .mdio_i(mdi));

   mdio_mgmt_master #(.MDC_HALF(HALF), .HAS_MDIO(0)) uut_nomdio (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata2), .mdc(mdc2), .mdio_o(mdo2),
      .mdio_oe(moe2), .mdio_i(1'b1));

   // pad with pull-up and a simple responding PHY
   assign mdi = moe ? mdo :
                ((resp_en && fcount >= 48 && fcount < 64) ? resp_word[4'(63 - fcount)] : 1'b1);

   always @(posedge clk) begin
      if (clr_req) begin
         fcount   <= 0;
         hi_cnt   <= 0;
         prev_mdc <= 1'b0;
      end else begin
         if (mdc) hi_cnt <= hi_cnt + 1;
         if (mdc && !prev_mdc && fcount < 64) begin
            cap_v[fcount[5:0]]   <= mdo;
            capoe_v[fcount[5:0]] <= moe;
         end
         if (!mdc && prev_mdc) fcount <= fcount + 1;
         prev_mdc <= mdc;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = rdata;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R4 actual=timeout expected=frame completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic        mdc_seen;
      repeat (4) @(negedge clk);
      rst_n = 1;

      // R9: reset state
      bus_read(A_CTRL, rd);  check(rd == 0, "R9 reset control", rd, 0);
      bus_read(A_RDATA, rd); check(rd == 0, "R9 reset read-data", rd, 0);
      check(mdc == 0 && moe == 0, "R9 reset pins", {mdc, moe}, 0);

      // R9: readback widths
      bus_write(A_ADDR, 32'hFFFF_FFFF);
      bus_read(A_ADDR, rd);  check(rd == 32'h7FF, "R9 address readback", rd, 32'h7FF);
      bus_write(A_WDATA, 32'hABCD_5A5A);
      bus_read(A_WDATA, rd); check(rd == 32'h5A5A, "R9 wdata readback", rd, 32'h5A5A);

      // R6: enable readback, both variants
      bus_write(A_CTRL, 32'h8);
      bus_read(A_CTRL, rd);  check(rd == 32'h8, "R6 enable readback", rd, 8);
      check(rdata2 == 0, "R6 no-mdio variant reads 0", rdata2, 0);

      // R5: start with enable clear is ignored
      bus_write(A_CTRL, 32'h1);
      bus_read(A_CTRL, rd);  check(rd == 0, "R5 status stays clear", rd, 0);
      mdc_seen = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (mdc || moe) mdc_seen = 1;
      end
      check(!mdc_seen, "R5 no MDC activity", mdc_seen, 0);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         logic        rdop, ren;
         logic [4:0]  phy, rg;
         logic [15:0] dat;
         logic [63:0] expf;
         logic [9:0]  got_ad;
         int          n, mism, oem;
         rdop = VEC[v][27]; phy = VEC[v][26:22]; rg = VEC[v][21:17];
         dat  = VEC[v][16:1]; ren = VEC[v][0];
         resp_word = dat; resp_en = ren;
         bus_write(A_ADDR, {21'b0, rdop, phy, rg});
         bus_write(A_WDATA, {16'b0, dat});
         @(negedge clk); clr_req = 1;
         @(negedge clk); clr_req = 0;
         bus_write(A_CTRL, 32'h9);
         bus_addr = A_CTRL;
         n = 0;
         while (rdata[0]) begin
            n++;
            @(negedge clk);
         end
         check(n == 128*HALF, "R4 busy length", n, 128*HALF);
         repeat (2) @(negedge clk);
         check(fcount == 64 && hi_cnt == 64*HALF, "R7 MDC periods and high time",
               {fcount[15:0], hi_cnt[15:0]}, {16'd64, 16'(64*HALF)});
         check(mdc == 0, "R7 MDC low after frame", mdc, 0);
         expf = {32'hFFFF_FFFF, 2'b01, (rdop ? 2'b10 : 2'b01), phy, rg, 2'b10, dat};
         mism = 0; oem = 0;
         for (int i = 0; i < 64; i++) begin
            logic eoe;
            eoe = !rdop || (i < 46);
            if (capoe_v[i] != eoe) oem++;
            if (eoe && cap_v[i] != expf[63-i]) mism++;
         end
         for (int k = 0; k < 10; k++) got_ad[9-k] = cap_v[36+k];
         check(got_ad == {phy, rg}, "R1 address fields in frame", got_ad, {phy, rg});
         if (rdop) begin
            check(mism == 0, "R3 read frame bits", mism, 0);
            check(oem == 0, "R3 release pattern", oem, 0);
            bus_read(A_RDATA, rd);
            if (ren) check(rd == {16'b0, dat}, "R3 read data", rd, dat);
            else     check(rd == 32'hFFFF, "R8 no reply reads all ones", rd, 32'hFFFF);
         end else begin
            check(mism == 0, "R2 write frame bits", mism, 0);
            check(oem == 0, "R2 driven all frame", oem, 0);
         end
      end

      // R6: variant without MDIO never started during the vectors
      check(rdata2 == 0 && mdc2 == 0 && moe2 == 0, "R6 no-mdio variant idle",
            {rdata2[3:0], mdc2, moe2}, 0);

      // R9: writes to the read-data register are ignored
      bus_write(A_RDATA, 32'h1234);
      bus_read(A_RDATA, rd);
      check(rd == 32'hFFFF, "R9 read-data not writable", rd, 32'hFFFF);

      summary();
      $finish;
   end
endmodule